// File: doc/BRIEF.md
# SET ADDRESS Auto-Responder

This block watches the setup stage of a USB device's default control endpoint. For every setup packet it decides whether the request can be answered in hardware. A SET ADDRESS request that passes every field check and arrives while the device is not yet configured is taken over. The block asks the handshake logic to acknowledge the status stage. Once that status stage completes, it commits the new address and reports the new device state.

Every other request goes to software through a one-cycle interrupt pulse. This covers all request codes other than SET ADDRESS, and any SET ADDRESS that breaks a rule. When the rejected request was a SET ADDRESS, an error pulse accompanies the interrupt.

The packet parser in front of this block supplies the decoded setup fields and a valid strobe. The transceiver side supplies a status-complete strobe and a bus-reset indication. The block supplies the current device address and the state to move to.

Top module: `addr_auto_resp`

## Requirements
- R1: After `rstN` is low, `devAddr` is 0, `newState` is 000b, and `statusAck`, `stateUpd`, `swIrq` and `reqErr` are all low.
- R2: A setup whose request code is not 05h causes `swIrq` to be high for exactly the cycle after the setup strobe, with `reqErr` low and `statusAck` low.
- R3: A request with code 05h and a request type other than 00h is not auto-handled. In the cycle after the strobe, `swIrq` and `reqErr` are both high.
- R4: A request with code 05h and a nonzero index field is rejected in the same way as in R3.
- R5: A request with code 05h and a nonzero length field is rejected in the same way as in R3.
- R6: A request with code 05h and a value field above 7Fh is rejected in the same way as in R3.
- R7: A request with code 05h that arrives while `curState` is 011b (configured) is rejected in the same way as in R3.
- R8: A conforming SET ADDRESS raises `statusAck` from the cycle after the setup strobe until the commit or an abort. It raises no `swIrq`.
- R9: A `statusDone` pulse while `statusAck` is high has three effects in the next cycle:
  - `devAddr` becomes the low 7 bits of the value field.
  - `stateUpd` pulses for one cycle.
  - `newState` becomes 010b (addressed) for a nonzero address, or 001b (default) for zero.
- R10: A `statusDone` pulse while `statusAck` is low changes neither `devAddr` nor `stateUpd`.
- R11: A new setup strobe while an address is pending drops the pending address. The new request is then judged on its own fields.
- R12: `busReset` takes priority over all other inputs. In the next cycle `devAddr` is 0, `statusAck` is low, `stateUpd` pulses and `newState` is 001b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | USB bus reset seen on the line |
| setupValid | input | 1 | One-cycle strobe: setup fields are valid |
| reqType | input | 8 | Request type byte |
| reqCode | input | 8 | Request code byte |
| reqValue | input | 16 | Value field |
| reqIndex | input | 16 | Index field |
| reqLength | input | 16 | Length field |
| curState | input | 3 | Current device state code |
| statusDone | input | 1 | Status stage completed successfully |
| devAddr | output | 7 | Committed device address |
| statusAck | output | 1 | Hardware will acknowledge the status stage |
| swIrq | output | 1 | Request handed to software (pulse) |
| reqErr | output | 1 | Rejected SET ADDRESS (pulse) |
| newState | output | 3 | Device state produced by this block |
| stateUpd | output | 1 | `newState` has just been updated (pulse) |

## Verification
Several properties are checked on every cycle:
- An error pulse never appears without the software interrupt.
- An acknowledge is never pending alongside an interrupt.
- The address never moves without a state-update pulse.
- A state update always carries a state code that matches the new address.
- A bus reset always leaves the address at zero.

Only the bench scenarios can show certain behaviours. These include the fault checks one field at a time, the rejection while configured, the drop of a pending address when a new setup arrives, and the address and state actually committed after a status stage.

// File: rtl/addr_resp_pkg.sv
package addr_resp_pkg;
  localparam int STATE_W = 3;
  localparam logic [STATE_W-1:0] ST_POWERED    = 3'b000;
  localparam logic [STATE_W-1:0] ST_DEFAULT    = 3'b001;
  localparam logic [STATE_W-1:0] ST_ADDRESSED  = 3'b010;
  localparam logic [STATE_W-1:0] ST_CONFIGURED = 3'b011;

  typedef struct packed {
    logic busRst;     // line reset: clear everything
    logic latchAddr;  // conforming request: hold the address
    logic commit;     // status stage done: apply held address
    logic toSw;       // hand request to software
    logic badReq;     // rejected request was a SET ADDRESS
  } resp_strobe_t;
endpackage

// File: rtl/addr_resp_ctrl.sv
module addr_resp_ctrl
  import addr_resp_pkg::*;
#(
  parameter int TYPE_W  = 8,
  parameter int FIELD_W = 16,
  parameter int ADDR_W  = 7,
  parameter logic [TYPE_W-1:0] SET_ADDR_CODE = 8'h05
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busReset,
  input  logic               setupValid,
  input  logic [TYPE_W-1:0]  reqType,
  input  logic [TYPE_W-1:0]  reqCode,
  input  logic [FIELD_W-1:0] reqValue,
  input  logic [FIELD_W-1:0] reqIndex,
  input  logic [FIELD_W-1:0] reqLength,
  input  logic [STATE_W-1:0] curState,
  input  logic               statusDone,
  output resp_strobe_t       strobes,
  output logic               pending
);
  localparam logic [FIELD_W-1:0] ADDR_MAX = FIELD_W'((1 << ADDR_W) - 1);
  localparam int NUM_FAULTS = 5;

  logic                  isSetAddr;
  logic [NUM_FAULTS-1:0] fault;
  logic                  wellFormed;

  always_comb begin
    isSetAddr  = (reqCode == SET_ADDR_CODE);
    fault[0]   = (reqType != '0);
    fault[1]   = (reqIndex != '0);
    fault[2]   = (reqLength != '0);
    fault[3]   = (reqValue > ADDR_MAX);
    fault[4]   = (curState == ST_CONFIGURED);
    wellFormed = isSetAddr && (fault == '0);

    strobes.busRst    = busReset;
    strobes.latchAddr = !busReset && setupValid && wellFormed;
    strobes.toSw      = !busReset && setupValid && !wellFormed;
    strobes.badReq    = !busReset && setupValid && !wellFormed && isSetAddr;
    strobes.commit    = !busReset && !setupValid && statusDone && pending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pending <= 1'b0;
    else if (strobes.busRst)    pending <= 1'b0;
    else if (setupValid)        pending <= wellFormed;
    else if (strobes.commit)    pending <= 1'b0;
  end

  // R11: a setup always re-decides the pending flag
  a_r11_setup_redecides: assert property (@(posedge clk) disable iff (!rstN)
    (setupValid && !busReset && !wellFormed) |=> !pending);
endmodule

// File: rtl/addr_resp_dp.sv
module addr_resp_dp
  import addr_resp_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  resp_strobe_t       strobes,
  input  logic [ADDR_W-1:0]  valueAddr,
  output logic [ADDR_W-1:0]  devAddr,
  output logic [STATE_W-1:0] newState,
  output logic               stateUpd,
  output logic               swIrq,
  output logic               reqErr
);
  logic [ADDR_W-1:0] heldAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
      devAddr  <= '0;
      newState <= ST_POWERED;
      stateUpd <= 1'b0;
      swIrq    <= 1'b0;
      reqErr   <= 1'b0;
    end else begin
      swIrq    <= strobes.toSw;
      reqErr   <= strobes.badReq;
      stateUpd <= strobes.busRst || strobes.commit;
      if (strobes.latchAddr) heldAddr <= valueAddr;
      if (strobes.busRst) begin
        devAddr  <= '0;
        newState <= ST_DEFAULT;
      end else if (strobes.commit) begin
        devAddr  <= heldAddr;
        newState <= (heldAddr != '0) ? ST_ADDRESSED : ST_DEFAULT;
      end
    end
  end

  // R3: an error pulse is always part of a software hand-off
  a_r3_err_with_irq: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> swIrq);
  // R10: the address only moves together with a state update
  a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    !stateUpd |-> $stable(devAddr));
  // R9: updated state matches the committed address
  a_r9_state_match: assert property (@(posedge clk) disable iff (!rstN)
    stateUpd |-> ((devAddr != '0) == (newState == ST_ADDRESSED)) &&
                 (newState == ST_ADDRESSED || newState == ST_DEFAULT));
  // R12: a bus reset leaves the address at zero
  a_r12_reset_addr: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busRst |=> (devAddr == '0) && stateUpd);
endmodule

// File: rtl/addr_auto_resp.sv
module addr_auto_resp
  import addr_resp_pkg::*;
#(
  parameter int TYPE_W  = 8,
  parameter int FIELD_W = 16,
  parameter int ADDR_W  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busReset,
  input  logic               setupValid,
  input  logic [TYPE_W-1:0]  reqType,
  input  logic [TYPE_W-1:0]  reqCode,
  input  logic [FIELD_W-1:0] reqValue,
  input  logic [FIELD_W-1:0] reqIndex,
  input  logic [FIELD_W-1:0] reqLength,
  input  logic [STATE_W-1:0] curState,
  input  logic               statusDone,
  output logic [ADDR_W-1:0]  devAddr,
  output logic               statusAck,
  output logic               swIrq,
  output logic               reqErr,
  output logic [STATE_W-1:0] newState,
  output logic               stateUpd
);
  resp_strobe_t strobes;

  addr_resp_ctrl #(.TYPE_W(TYPE_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busReset(busReset), .setupValid(setupValid),
    .reqType(reqType), .reqCode(reqCode), .reqValue(reqValue),
    .reqIndex(reqIndex), .reqLength(reqLength), .curState(curState),
    .statusDone(statusDone), .strobes(strobes), .pending(statusAck)
  );

  addr_resp_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .valueAddr(reqValue[ADDR_W-1:0]), .devAddr(devAddr),
    .newState(newState), .stateUpd(stateUpd), .swIrq(swIrq), .reqErr(reqErr)
  );

  // R8: an acknowledge is never pending while software is interrupted
  a_r8_ack_excl: assert property (@(posedge clk) disable iff (!rstN)
    swIrq |-> !statusAck);
endmodule

// File: tb/tb_addr_auto_resp.sv
module tb_addr_auto_resp;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 1'b0, setupValid = 1'b0, statusDone = 1'b0;
  logic [7:0] reqType = '0, reqCode = '0;
  logic [15:0] reqValue = '0, reqIndex = '0, reqLength = '0;
  logic [2:0] curState = 3'b001;
  logic [6:0] devAddr;
  logic statusAck, swIrq, reqErr, stateUpd;
  logic [2:0] newState;

  int total = 0, bad = 0, cycles = 0;
  string curReq = "R1";

  // reference model state
  int eAddr = 0, ePend = 0, eState = 0;
  bit eAck = 0, eIrq = 0, eErr = 0, eUpd = 0;

  always #5 clk = ~clk;

  addr_auto_resp dut (
    .clk(clk), .rstN(rstN), .busReset(busReset), .setupValid(setupValid),
    .reqType(reqType), .reqCode(reqCode), .reqValue(reqValue),
    .reqIndex(reqIndex), .reqLength(reqLength), .curState(curState),
    .statusDone(statusDone), .devAddr(devAddr), .statusAck(statusAck),
    .swIrq(swIrq), .reqErr(reqErr), .newState(newState), .stateUpd(stateUpd)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eAddr = 0; ePend = 0; eState = 0; eAck = 0; eIrq = 0; eErr = 0; eUpd = 0;
    end else begin
      eIrq = 0; eErr = 0; eUpd = 0;
      if (busReset) begin
        eAddr = 0; eAck = 0; eUpd = 1; eState = 1;
      end else if (setupValid) begin
        bit isSet, faulty;
        isSet  = (reqCode == 8'h05);
        faulty = (reqType != 0) || (reqIndex != 0) || (reqLength != 0) ||
                 (reqValue > 16'h7F) || (curState == 3'b011);
        if (isSet && !faulty) begin
          eAck = 1; ePend = int'(reqValue);
        end else begin
          eAck = 0; eIrq = 1; eErr = isSet;
        end
      end else if (statusDone && eAck) begin
        eAddr = ePend; eAck = 0; eUpd = 1; eState = (ePend != 0) ? 2 : 1;
      end
    end
  end

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    check("devAddr", int'(devAddr), eAddr);
    check("statusAck", int'(statusAck), int'(eAck));
    check("swIrq", int'(swIrq), int'(eIrq));
    check("reqErr", int'(reqErr), int'(eErr));
    check("stateUpd", int'(stateUpd), int'(eUpd));
    check("newState", int'(newState), eState);
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] t, input logic [7:0] c,
                       input logic [15:0] v, input logic [15:0] ix,
                       input logic [15:0] ln);
    @(negedge clk);
    reqType = t; reqCode = c; reqValue = v; reqIndex = ix; reqLength = ln;
    setupValid = 1'b1;
    @(negedge clk);
    setupValid = 1'b0;
  endtask

  task automatic done();
    @(negedge clk);
    statusDone = 1'b1;
    @(negedge clk);
    statusDone = 1'b0;
  endtask

  initial begin
    idle(1);
    curReq = "R1";
    check("R1 reset addr", int'(devAddr), 0);
    check("R1 reset irq", int'(swIrq), 0);
    @(negedge clk); rstN = 1'b1;
    idle(2);
    curReq = "R12"; @(negedge clk); busReset = 1'b1; @(negedge clk); busReset = 1'b0;
    idle(2);
    curReq = "R2";  setup(8'h80, 8'h06, 16'h0100, 0, 16'h0012); idle(2);
    curReq = "R2";  setup(8'h00, 8'h09, 16'h0001, 0, 0); idle(2);
    curReq = "R3";  setup(8'h02, 8'h05, 16'h0010, 0, 0); idle(2);
    curReq = "R4";  setup(8'h00, 8'h05, 16'h0010, 16'h0001, 0); idle(2);
    curReq = "R5";  setup(8'h00, 8'h05, 16'h0010, 0, 16'h0002); idle(2);
    curReq = "R6";  setup(8'h00, 8'h05, 16'h0080, 0, 0); idle(2);
    curReq = "R10"; done(); idle(2);
    curReq = "R8";  setup(8'h00, 8'h05, 16'h007F, 0, 0); idle(3);
    curReq = "R9";  done(); idle(2);
    check("R9 addr 7Fh", int'(devAddr), 127);
    check("R9 addressed", int'(newState), 2);
    curReq = "R8";  setup(8'h00, 8'h05, 16'h0000, 0, 0); idle(1);
    curReq = "R9";  done(); idle(2);
    check("R9 zero addr default", int'(newState), 1);
    curReq = "R11"; setup(8'h00, 8'h05, 16'h0033, 0, 0);
    setup(8'h80, 8'h06, 16'h0100, 0, 16'h0040);
    done(); idle(2);
    check("R11 address not taken", int'(devAddr), 0);
    curReq = "R7";  curState = 3'b011;
    setup(8'h00, 8'h05, 16'h0022, 0, 0); idle(1); done(); idle(2);
    curState = 3'b001;
    curReq = "R9";  setup(8'h00, 8'h05, 16'h0045, 0, 0); done(); idle(2);
    curReq = "R12"; setup(8'h00, 8'h05, 16'h0011, 0, 0);
    @(negedge clk); busReset = 1'b1; statusDone = 1'b1;
    @(negedge clk); busReset = 1'b0; statusDone = 1'b0;
    idle(2);
    check("R12 addr cleared", int'(devAddr), 0);
    curReq = "R10"; done(); idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=<5000 cycles", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule